// File: doc/BRIEF.md
# Exception Prioritiser and Entry Controller

This block sits beside a processor core's execute stage. Each cycle it samples seven exception request lines together with the current status word and the address of the next sequential instruction. It masks any interrupt request that the status word disables, picks the single most urgent request that is left, and produces everything the core needs to enter the handler: the vector address, the new status word, the copy of the old status word for the handler's saved-status register, and the return-link value.

The results are registered. They appear, with an `entry_o` strobe, one clock after the requests were sampled, and they hold for exactly that one cycle. The core writes them into its banked registers and redirects fetch. In the cycle right after a strobe, requests other than reset are not accepted. A request that is still held is taken again one cycle later. Pipeline flushing, return from an exception and the handler code are left to the surrounding logic.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When more than one request is accepted in the same cycle, the winner follows this order, most urgent first: reset, data abort, FIQ, IRQ, prefetch abort, then undefined instruction and software interrupt.
- R2: `vector_o` equals VEC_BASE plus the source's offset. The offsets are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C.
- R3: `cpsr_o[4:0]` carries the target mode. Reset and software interrupt use 5'b10011. Both abort kinds use 5'b10111. Undefined uses 5'b11011. IRQ uses 5'b10010 and FIQ uses 5'b10001.
- R4: On any entry except reset, `lr_o` equals the sampled `pc_next_i` and `spsr_o` equals the sampled `cpsr_i`. On a reset entry both are zero.
- R5: On every entry, `cpsr_o[7]` (IRQ mask) is 1 and `cpsr_o[5]` (T bit) is 0, and `cpsr_o[31:8]` is copied from `cpsr_i`.
- R6: `cpsr_o[6]` (FIQ mask) is 1 on reset and FIQ entries. On every other entry it is copied from `cpsr_i[6]`.
- R7: An FIQ request is ignored while `cpsr_i[6]` is 1, and an IRQ request is ignored while `cpsr_i[7]` is 1. A lower-priority request that is present then wins, and with no other request there is no entry.
- R8: If both undefined instruction and software interrupt are requested together and nothing more urgent is present, undefined instruction wins.
- R9: `entry_o` and all result outputs are registered and valid in the cycle after the requests are sampled. When no entry is taken, every output is zero.
- R10: In the cycle in which `entry_o` is 1, all requests except reset are ignored, so a held request produces a strobe only every second cycle. A reset request is still accepted in that cycle.
- R11: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_req_i | input | 1 | Reset exception request |
| dabt_req_i | input | 1 | Data abort request |
| fiq_req_i | input | 1 | Fast interrupt request |
| irq_req_i | input | 1 | Normal interrupt request |
| pabt_req_i | input | 1 | Prefetch abort request |
| swi_req_i | input | 1 | Software interrupt request |
| und_req_i | input | 1 | Undefined instruction request |
| pc_next_i | input | XLEN | Address of the instruction after the excepting one |
| cpsr_i | input | XLEN | Current status word |
| entry_o | output | 1 | One-cycle entry strobe |
| vector_o | output | XLEN | Handler vector address |
| cpsr_o | output | XLEN | New status word |
| spsr_o | output | XLEN | Value for the new mode's saved-status register |
| lr_o | output | XLEN | Value for the new mode's link register |

## Verification
Every result has the same latency. Each output is due exactly one rising edge after its request is sampled, and it is gone one edge later. The bench drives inputs on the falling edge and reads the outputs at the next falling edge, which is half a period after the register updates. After each table vector the bench drives one idle cycle, so the blocking cycle of R10 never hides a vector. Separate directed sequences then hold a request across consecutive edges and place a reset request into the blocked cycle, so that the pulse spacing is checked edge by edge.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned SRC_W   = $clog2(NUM_SRC);

  // rank order: lower value wins
  typedef enum logic [SRC_W-1:0] {
    SRC_RST  = 3'd0,
    SRC_DABT = 3'd1,
    SRC_FIQ  = 3'd2,
    SRC_IRQ  = 3'd3,
    SRC_PABT = 3'd4,
    SRC_UND  = 3'd5,
    SRC_SWI  = 3'd6
  } exc_src_e;

  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  localparam int unsigned BIT_T = 5;
  localparam int unsigned BIT_F = 6;
  localparam int unsigned BIT_I = 7;

  function automatic logic [4:0] src_mode(exc_src_e s);
    case (s)
      SRC_RST, SRC_SWI:   src_mode = MODE_SVC;
      SRC_DABT, SRC_PABT: src_mode = MODE_ABT;
      SRC_FIQ:            src_mode = MODE_FIQ;
      SRC_IRQ:            src_mode = MODE_IRQ;
      default:            src_mode = MODE_UND;
    endcase
  endfunction

  function automatic logic [7:0] src_offset(exc_src_e s);
    case (s)
      SRC_RST:  src_offset = 8'h00;
      SRC_UND:  src_offset = 8'h04;
      SRC_SWI:  src_offset = 8'h08;
      SRC_PABT: src_offset = 8'h0C;
      SRC_DABT: src_offset = 8'h10;
      SRC_IRQ:  src_offset = 8'h18;
      default:  src_offset = 8'h1C;
    endcase
  endfunction
endpackage

// File: rtl/exc_pick.sv
module exc_pick #(
  parameter int unsigned NUM = 7,
  localparam int unsigned IW = $clog2(NUM)
) (
  input  logic [NUM-1:0] req_i,
  output logic           valid_o,
  output logic [IW-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/exc_entry_build.sv
module exc_entry_build
  import exc_entry_pkg::*;
#(
  parameter int unsigned      XLEN     = 32,
  parameter logic [XLEN-1:0]  VEC_BASE = '0
) (
  input  exc_src_e        src_i,
  input  logic [XLEN-1:0] pc_next_i,
  input  logic [XLEN-1:0] cpsr_i,
  output logic [XLEN-1:0] vector_o,
  output logic [XLEN-1:0] cpsr_o,
  output logic [XLEN-1:0] spsr_o,
  output logic [XLEN-1:0] lr_o
);
  logic is_rst;
  assign is_rst = (src_i == SRC_RST);

  assign vector_o = VEC_BASE + XLEN'(src_offset(src_i));

  always_comb begin
    cpsr_o        = cpsr_i;
    cpsr_o[4:0]   = src_mode(src_i);
    cpsr_o[BIT_T] = 1'b0;
    cpsr_o[BIT_I] = 1'b1;
    if (is_rst || src_i == SRC_FIQ) cpsr_o[BIT_F] = 1'b1;
  end

  assign spsr_o = is_rst ? '0 : cpsr_i;
  assign lr_o   = is_rst ? '0 : pc_next_i;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rst_req_i,
  input  logic            dabt_req_i,
  input  logic            fiq_req_i,
  input  logic            irq_req_i,
  input  logic            pabt_req_i,
  input  logic            swi_req_i,
  input  logic            und_req_i,
  input  logic [XLEN-1:0] pc_next_i,
  input  logic [XLEN-1:0] cpsr_i,
  output logic            entry_o,
  output logic [XLEN-1:0] vector_o,
  output logic [XLEN-1:0] cpsr_o,
  output logic [XLEN-1:0] spsr_o,
  output logic [XLEN-1:0] lr_o
);
  logic [NUM_SRC-1:0] rank_req, rank_acc;
  logic               take;
  logic [SRC_W-1:0]   win_idx;
  logic [XLEN-1:0]    vec_d, cpsr_d, spsr_d, lr_d;

  always_comb begin
    rank_req           = '0;
    rank_req[SRC_RST]  = rst_req_i;
    rank_req[SRC_DABT] = dabt_req_i;
    rank_req[SRC_FIQ]  = fiq_req_i & ~cpsr_i[BIT_F];
    rank_req[SRC_IRQ]  = irq_req_i & ~cpsr_i[BIT_I];
    rank_req[SRC_PABT] = pabt_req_i;
    rank_req[SRC_UND]  = und_req_i;
    rank_req[SRC_SWI]  = swi_req_i;
  end

  // only reset gets through in the cycle after a strobe
  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_block
      if (g == SRC_RST) begin : g_pass
        assign rank_acc[g] = rank_req[g];
      end else begin : g_gate
        assign rank_acc[g] = rank_req[g] & ~entry_o;
      end
    end
  endgenerate

  exc_pick #(.NUM(NUM_SRC)) u_pick (
    .req_i  (rank_acc),
    .valid_o(take),
    .idx_o  (win_idx)
  );

  exc_entry_build #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_build (
    .src_i    (exc_src_e'(win_idx)),
    .pc_next_i(pc_next_i),
    .cpsr_i   (cpsr_i),
    .vector_o (vec_d),
    .cpsr_o   (cpsr_d),
    .spsr_o   (spsr_d),
    .lr_o     (lr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_o  <= 1'b0;
      vector_o <= '0;
      cpsr_o   <= '0;
      spsr_o   <= '0;
      lr_o     <= '0;
    end else if (take) begin
      entry_o  <= 1'b1;
      vector_o <= vec_d;
      cpsr_o   <= cpsr_d;
      spsr_o   <= spsr_d;
      lr_o     <= lr_d;
    end else begin
      entry_o  <= 1'b0;
      vector_o <= '0;
      cpsr_o   <= '0;
      spsr_o   <= '0;
      lr_o     <= '0;
    end
  end

  assert_rst_wins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> entry_o && vector_o == VEC_BASE && cpsr_o[4:0] == MODE_SVC);

  assert_rst_clears_link_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> lr_o == '0 && spsr_o == '0);

  assert_mask_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> cpsr_o[BIT_I] && !cpsr_o[BIT_T]);

  assert_masked_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i && cpsr_i[BIT_I] && !rst_req_i && !dabt_req_i && !fiq_req_i
     && !pabt_req_i && !swi_req_i && !und_req_i) |=> !entry_o);

  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_o && !rst_req_i) |=> !entry_o);

  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !entry_o |-> vector_o == '0 && cpsr_o == '0 && lr_o == '0 && spsr_o == '0);
endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;
  localparam int unsigned XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req, dabt_req, fiq_req, irq_req, pabt_req, swi_req, und_req;
  logic [XLEN-1:0] pc_next, cpsr_in;
  logic entry;
  logic [XLEN-1:0] vec, cpsr_out, spsr, lr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_entry_ctrl #(.XLEN(XLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rst_req_i(rst_req), .dabt_req_i(dabt_req), .fiq_req_i(fiq_req),
    .irq_req_i(irq_req), .pabt_req_i(pabt_req), .swi_req_i(swi_req),
    .und_req_i(und_req), .pc_next_i(pc_next), .cpsr_i(cpsr_in),
    .entry_o(entry), .vector_o(vec), .cpsr_o(cpsr_out),
    .spsr_o(spsr), .lr_o(lr)
  );

  // req bits: [6]rst [5]dabt [4]fiq [3]irq [2]pabt [1]swi [0]und
  typedef struct packed {
    logic [6:0]  req;
    logic [31:0] cpsr;
    logic        ent;
    logic [7:0]  vec;
    logic [4:0]  mode;
    logic        f;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{7'b0000010, 32'h0000_0010, 1'b1, 8'h08, 5'b10011, 1'b0},
    '{7'b0000001, 32'h0000_0010, 1'b1, 8'h04, 5'b11011, 1'b0},
    '{7'b0000011, 32'h0000_0010, 1'b1, 8'h04, 5'b11011, 1'b0},
    '{7'b0000100, 32'h0000_0010, 1'b1, 8'h0C, 5'b10111, 1'b0},
    '{7'b0001000, 32'h0000_0010, 1'b1, 8'h18, 5'b10010, 1'b0},
    '{7'b0010000, 32'h0000_0010, 1'b1, 8'h1C, 5'b10001, 1'b1},
    '{7'b0100000, 32'h0000_0010, 1'b1, 8'h10, 5'b10111, 1'b0},
    '{7'b0111111, 32'h0000_0010, 1'b1, 8'h10, 5'b10111, 1'b0},
    '{7'b0011000, 32'h0000_0010, 1'b1, 8'h1C, 5'b10001, 1'b1},
    '{7'b0001100, 32'h0000_0090, 1'b1, 8'h0C, 5'b10111, 1'b0},
    '{7'b0010000, 32'h0000_0050, 1'b0, 8'h00, 5'b00000, 1'b0},
    '{7'b0011000, 32'h0000_0050, 1'b1, 8'h18, 5'b10010, 1'b1},
    '{7'b1111111, 32'h0000_0010, 1'b1, 8'h00, 5'b10011, 1'b1},
    '{7'b0001000, 32'hF000_0030, 1'b1, 8'h18, 5'b10010, 1'b0}
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] r, input logic [31:0] c, input logic [31:0] pc);
    {rst_req, dabt_req, fiq_req, irq_req, pabt_req, swi_req, und_req} = r;
    cpsr_in = c;
    pc_next = pc;
  endtask

  task automatic check_idle(input string rq);
    check(rq, {31'd0, entry}, 32'd0);
    check(rq, vec | cpsr_out | spsr | lr, 32'd0);
  endtask

  initial begin
    drive(7'd0, 32'h0, 32'h0);
    repeat (2) @(negedge clk);
    check_idle("R11 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R9 idle");

    for (int i = 0; i < NV; i++) begin
      logic [31:0] pc;
      logic [31:0] ecpsr;
      pc = 32'h0000_1000 + 32'(i) * 32'h40;
      drive(TBL[i].req, TBL[i].cpsr, pc);
      @(negedge clk);
      drive(7'd0, 32'h0, 32'h0);
      if (!TBL[i].ent) begin
        check_idle("R7 masked FIQ no entry");
      end else begin
        ecpsr = {TBL[i].cpsr[31:8], 1'b1, TBL[i].f, 1'b0, TBL[i].mode};
        check("R9 strobe", {31'd0, entry}, 32'd1);
        check("R1 R2 R8 vector", vec, {24'd0, TBL[i].vec});
        check("R3 R5 R6 cpsr", cpsr_out, ecpsr);
        if (TBL[i].req[6]) begin
          check("R4 reset lr", lr, 32'd0);
          check("R4 reset spsr", spsr, 32'd0);
        end else begin
          check("R4 lr", lr, pc);
          check("R4 spsr", spsr, TBL[i].cpsr);
        end
      end
      @(negedge clk);
      check_idle("R9 one-cycle pulse");
    end

    // R10: held IRQ gives strobes on alternate cycles
    drive(7'b0001000, 32'h10, 32'h2000);
    @(negedge clk);
    check("R10 held first", {31'd0, entry}, 32'd1);
    @(negedge clk);
    check("R10 held blocked", {31'd0, entry}, 32'd0);
    @(negedge clk);
    check("R10 held again", {31'd0, entry}, 32'd1);
    check("R10 held vector", vec, 32'h18);
    drive(7'd0, 32'h0, 32'h0);
    @(negedge clk);

    // R10: reset request accepted in the blocked cycle
    drive(7'b0000010, 32'h10, 32'h3000);
    @(negedge clk);
    check("R10 swi entry", vec, 32'h08);
    drive(7'b1000000, 32'h10, 32'h3000);
    @(negedge clk);
    check("R10 reset in blocked cycle", {31'd0, entry}, 32'd1);
    check("R10 reset vector", vec, 32'h0);
    drive(7'd0, 32'h0, 32'h0);
    @(negedge clk);
    check_idle("R9 after reset entry");

    // R11: async reset clears a pending strobe
    drive(7'b0100000, 32'h10, 32'h4000);
    @(negedge clk);
    check("R11 pre-reset strobe", {31'd0, entry}, 32'd1);
    rst_n = 1'b0;
    #1;
    check_idle("R11 async clear");
    drive(7'd0, 32'h0, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule